// File: doc/BRIEF.md
# Quad DAC Register and Update Controller

This block keeps the digital state behind a four-channel converter. Each channel has a staged input register and an active output register; the active register drives the 16-bit converter code, and a 2-bit field per channel tells the analog output stage how to terminate a channel that is switched off. A serial frame receiver elsewhere hands over each finished frame as an opcode, an address and a 20-bit operand. Those three fields carry the frame's low 28 bits. The operand holds the code in bits 19:4, and the control fields sit in its low bits. The receiver also pulses a start strobe when a frame opens.

Two board pins act alongside the commands. An active-low update pin copies staged values into the active registers. A per-channel override mask lets chosen channels update by themselves, without the pin. An active-low clear pin loads a programmable clear code into every register on its falling edge, and update-pin activity is ignored while it stays low. A strap pin chooses the code that reset loads: zero or midscale. Both board pins pass through synchronizers before use, so a pin change acts on the third rising clock edge after it.

Top module: `quad_dac_regctl`

## Requirements
- R1: Reset (the rst input, or opcode 0111) loads every input and output register with 0x0000 when the strap is low and with 0x8000 when it is high. It also sets every mode field to 00, clears the override mask to 0000 and sets the clear code to 0x0000.
- R2: Opcode 0000 writes the operand code into the input register of the addressed channel. The output does not change while the update pin is high and the channel's mask bit is 0.
- R3: Opcode 0001 copies the addressed channel's input register into its output register.
- R4: Opcode 0010 writes the addressed channel's input register. In the same cycle, every channel's output register then takes its input register value.
- R5: Opcode 0011 writes the operand code into both registers of the addressed channel.
- R6: Address 0000 selects A, 0001 selects B, 0010 selects C, 0011 selects D and 1111 selects all four. Any other address changes nothing.
- R7: Opcode 0100 sets the mode field to operand bits 9:8 on each channel whose select bit is 1. Bit 0 selects A, bit 1 B, bit 2 C and bit 3 D. The modes are 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground and 11 high impedance. No code changes.
- R8: Opcode 0101 sets the clear code from operand bits 1:0: 00 gives 0x0000, 01 gives 0x8000 and 10 gives 0xFFFF. 11 leaves the clear code unchanged.
- R9: Opcode 0110 loads the override mask from operand bits 3:0, with bit 0 for A. A channel whose mask bit is 1 updates its output whenever its input register is written. An unmasked channel does not.
- R10: While the synchronized update pin is low and the clear pin is high, each output register follows its input register. A write made in that state reaches the output in the same cycle.
- R11: A falling edge on the clear pin loads every input and output register with the clear code. While the clear pin is low, a low update pin changes no output.
- R12: A command whose frame saw a clear falling edge after its start strobe, or in the same cycle as its valid strobe, is dropped.
- R13: Opcodes 1000 through 1111 change no code and no mode.
- R14: Setting a channel back to mode 00 keeps its output code. The staged value appears only through a later update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| por_mid_i | input | 1 | Strap: 1 selects midscale as the reset code |
| upd_n_i | input | 1 | Active-low update pin, asynchronous |
| clr_n_i | input | 1 | Active-low clear pin, asynchronous, falling-edge action |
| frm_start_i | input | 1 | Pulse when a serial frame opens |
| cmd_valid_i | input | 1 | Pulse when a frame completes |
| cmd_op_i | input | 4 | Opcode |
| cmd_addr_i | input | 4 | Channel address |
| cmd_oper_i | input | 20 | Operand: code in 19:4, control fields in low bits |
| code_o | output | 64 | Active codes, channel A in bits 15:0 |
| mode_o | output | 8 | Output modes, channel A in bits 1:0 |

## Verification
The bench targets the interaction between staged and active registers. It checks that a write-input with the pin high leaves the output alone. It checks that a write-then-update-all also moves channels that were never addressed. It checks that leaving a low-power mode does not silently pull in a staged value. A design that copied on every write, or only refreshed the addressed channel, would show the wrong code on one of these checks. The clear path is tested in three ways: the no-op clear-code value, the update pin held low during a clear, and a clear arriving in the middle of a frame. A design that skipped any of these would show the wrong value in the output registers. Reserved addresses and opcodes, and a software reset that must also empty the mask and the clear code, complete the set.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam logic [3:0] OP_WR_IN      = 4'h0;
    localparam logic [3:0] OP_UPD        = 4'h1;
    localparam logic [3:0] OP_WR_UPD_ALL = 4'h2;
    localparam logic [3:0] OP_WR_UPD     = 4'h3;
    localparam logic [3:0] OP_PWR        = 4'h4;
    localparam logic [3:0] OP_CLR_CODE   = 4'h5;
    localparam logic [3:0] OP_MASK       = 4'h6;
    localparam logic [3:0] OP_RESET      = 4'h7;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef enum logic [1:0] {
        PD_ON   = 2'b00,
        PD_1K   = 2'b01,
        PD_100K = 2'b10,
        PD_HIZ  = 2'b11
    } pd_mode_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'b00,
        CC_MID  = 2'b01,
        CC_FULL = 2'b10,
        CC_KEEP = 2'b11
    } clr_sel_e;

    // Channel index ch is hit by its own address or by the broadcast address.
    function automatic logic addr_hits(input logic [3:0] addr, input int ch);
        return (addr == ADDR_ALL) || (addr == 4'(ch));
    endfunction

endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
    import qdac_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_start,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_op,
    input  logic [3:0]          cmd_addr,
    input  logic [CODE_W+3:0]   cmd_oper,
    input  logic                clr_fall,
    input  logic                clr_low,
    input  logic                upd_low,
    input  logic [NCH-1:0]      mask_q,
    output logic [NCH-1:0]      wr_in,
    output logic [NCH-1:0]      upd_out,
    output logic [NCH-1:0]      pd_set,
    output pd_mode_e            pd_mode,
    output logic [CODE_W-1:0]   wr_code,
    output logic                sw_reset,
    output logic                cc_we,
    output clr_sel_e            cc_sel,
    output logic                mask_we,
    output logic [NCH-1:0]      mask_val
);
    localparam int OPER_W = CODE_W + 4;

    logic frame_open_q;
    logic aborted_q;
    logic exec;
    logic pin_upd;
    logic is_wr_any;

    // A clear edge seen inside an open frame poisons that frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_open_q <= 1'b0;
            aborted_q    <= 1'b0;
        end else if (frm_start) begin
            frame_open_q <= 1'b1;
            aborted_q    <= clr_fall;
        end else if (cmd_valid) begin
            frame_open_q <= 1'b0;
            aborted_q    <= 1'b0;
        end else if (clr_fall && frame_open_q) begin
            aborted_q    <= 1'b1;
        end
    end

    assign exec      = cmd_valid && !clr_fall && !aborted_q;
    assign pin_upd   = upd_low && !clr_low;
    assign is_wr_any = (cmd_op == OP_WR_IN) || (cmd_op == OP_WR_UPD_ALL) || (cmd_op == OP_WR_UPD);

    assign wr_code  = cmd_oper[OPER_W-1:4];
    assign pd_mode  = pd_mode_e'(cmd_oper[9:8]);
    assign cc_sel   = clr_sel_e'(cmd_oper[1:0]);
    assign mask_val = cmd_oper[NCH-1:0];
    assign sw_reset = exec && (cmd_op == OP_RESET);
    assign cc_we    = exec && (cmd_op == OP_CLR_CODE);
    assign mask_we  = exec && (cmd_op == OP_MASK);

    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            logic sel;
            sel         = addr_hits(cmd_addr, ch);
            wr_in[ch]   = exec && sel && is_wr_any;
            upd_out[ch] = pin_upd
                        || (exec && sel && (cmd_op == OP_WR_IN) && mask_q[ch])
                        || (exec && sel && (cmd_op == OP_UPD))
                        || (exec && (cmd_op == OP_WR_UPD_ALL))
                        || (exec && sel && (cmd_op == OP_WR_UPD));
            pd_set[ch]  = exec && (cmd_op == OP_PWR) && cmd_oper[ch];
        end
    end

    AST_ABORTED_FRAME_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && aborted_q && !upd_low) |-> (wr_in == '0 && upd_out == '0 && !sw_reset && !cc_we && !mask_we)) // R12
        else $error("aborted frame still acted");

    AST_CLEAR_LOW_BLOCKS_PIN: assert property (@(posedge clk) disable iff (rst)
        (clr_low && !cmd_valid) |-> (upd_out == '0)) // R11
        else $error("update pin acted while clear low");
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
    import qdac_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_por,
    input  logic [CODE_W-1:0] por_code,
    input  logic              clr_load,
    input  logic [CODE_W-1:0] clr_code,
    input  logic              wr_in,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              upd_out,
    input  logic              pd_set,
    input  pd_mode_e          pd_mode,
    output logic [CODE_W-1:0] out_q,
    output pd_mode_e          mode_q
);
    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] in_nxt;

    assign in_nxt = wr_in ? wr_code : in_q;

    always_ff @(posedge clk) begin
        if (load_por) begin
            in_q   <= por_code;
            out_q  <= por_code;
            mode_q <= PD_ON;
        end else if (clr_load) begin
            in_q   <= clr_code;
            out_q  <= clr_code;
        end else begin
            in_q <= in_nxt;
            if (upd_out) out_q  <= in_nxt;
            if (pd_set)  mode_q <= pd_mode;
        end
    end

    AST_POR_CODE_LOADED: assert property (@(posedge clk) disable iff (rst)
        load_por |=> (out_q == $past(por_code) && in_q == $past(por_code) && mode_q == PD_ON)) // R1
        else $error("reset code not loaded");

    AST_CLEAR_CODE_LOADED: assert property (@(posedge clk) disable iff (rst)
        (clr_load && !load_por) |=> (out_q == $past(clr_code) && in_q == $past(clr_code))) // R11
        else $error("clear code not loaded");

    AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
        (pd_set && !wr_in && !upd_out && !clr_load && !load_por) |=> ($stable(out_q) && mode_q == $past(pd_mode))) // R7
        else $error("power mode write disturbed code");

    AST_OUT_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (!upd_out && !clr_load && !load_por) |=> $stable(out_q)) // R2
        else $error("output moved without update");
endmodule

// File: rtl/quad_dac_regctl.sv
module quad_dac_regctl
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CODE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  por_mid_i,
    input  logic                  upd_n_i,
    input  logic                  clr_n_i,
    input  logic                  frm_start_i,
    input  logic                  cmd_valid_i,
    input  logic [3:0]            cmd_op_i,
    input  logic [3:0]            cmd_addr_i,
    input  logic [CODE_W+3:0]     cmd_oper_i,
    output logic [NCH*CODE_W-1:0] code_o,
    output logic [NCH*2-1:0]      mode_o
);
    localparam logic [CODE_W-1:0] CODE_ZERO = '0;
    localparam logic [CODE_W-1:0] CODE_MID  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_FULL = '1;

    logic upd_lvl, clr_lvl, clr_prev_q, clr_fall;
    logic [NCH-1:0] wr_in, upd_out, pd_set, mask_val;
    logic [NCH-1:0] mask_q;
    pd_mode_e       pd_mode;
    clr_sel_e       cc_sel, cc_sel_q;
    logic [CODE_W-1:0] wr_code, por_code, clr_code;
    logic sw_reset, cc_we, mask_we, load_por;

    qdac_pin_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk(clk), .pin_i(upd_n_i), .level_o(upd_lvl));
    qdac_pin_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk(clk), .pin_i(clr_n_i), .level_o(clr_lvl));

    always_ff @(posedge clk) clr_prev_q <= clr_lvl;
    assign clr_fall = clr_prev_q && !clr_lvl && !rst;

    qdac_cmd_decode #(.NCH(NCH), .CODE_W(CODE_W)) u_dec (
        .clk(clk), .rst(rst), .frm_start(frm_start_i), .cmd_valid(cmd_valid_i),
        .cmd_op(cmd_op_i), .cmd_addr(cmd_addr_i), .cmd_oper(cmd_oper_i),
        .clr_fall(clr_fall), .clr_low(!clr_lvl), .upd_low(!upd_lvl), .mask_q(mask_q),
        .wr_in(wr_in), .upd_out(upd_out), .pd_set(pd_set), .pd_mode(pd_mode),
        .wr_code(wr_code), .sw_reset(sw_reset), .cc_we(cc_we), .cc_sel(cc_sel),
        .mask_we(mask_we), .mask_val(mask_val));

    assign load_por = rst || sw_reset;
    assign por_code = por_mid_i ? CODE_MID : CODE_ZERO;

    always_ff @(posedge clk) begin
        if (load_por) begin
            mask_q   <= '0;
            cc_sel_q <= CC_ZERO;
        end else begin
            if (mask_we) mask_q <= mask_val;
            if (cc_we && cc_sel != CC_KEEP) cc_sel_q <= cc_sel;
        end
    end

    always_comb begin
        case (cc_sel_q)
            CC_MID:  clr_code = CODE_MID;
            CC_FULL: clr_code = CODE_FULL;
            default: clr_code = CODE_ZERO;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pd_mode_e mode_q;
        qdac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk(clk), .rst(rst), .load_por(load_por), .por_code(por_code),
            .clr_load(clr_fall), .clr_code(clr_code),
            .wr_in(wr_in[ch]), .wr_code(wr_code), .upd_out(upd_out[ch]),
            .pd_set(pd_set[ch]), .pd_mode(pd_mode),
            .out_q(code_o[ch*CODE_W +: CODE_W]), .mode_q(mode_q));
        assign mode_o[ch*2 +: 2] = mode_q;
    end

    AST_SWRESET_CLEARS_MASK: assert property (@(posedge clk) disable iff (rst)
        sw_reset |=> (mask_q == '0 && cc_sel_q == CC_ZERO)) // R1
        else $error("software reset left mask or clear code");

    AST_CLR_KEEP_IS_NOP: assert property (@(posedge clk) disable iff (rst)
        (cc_we && cc_sel == CC_KEEP) |=> $stable(cc_sel_q)) // R8
        else $error("clear-code keep value altered register");
endmodule

// File: tb/quad_dac_regctl_tb_top.sv
`timescale 1ns/1ps
module quad_dac_regctl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_mid = 1'b0;
    logic upd_n = 1'b1;
    logic clr_n = 1'b1;
    logic frm_start = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [3:0] cmd_addr = '0;
    logic [19:0] cmd_oper = '0;
    logic [63:0] code_o;
    logic [7:0]  mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_code [4];
    logic [1:0]  exp_mode [4];

    always #2.5 clk = ~clk;

    quad_dac_regctl dut_i (
        .clk(clk), .rst(rst), .por_mid_i(por_mid), .upd_n_i(upd_n), .clr_n_i(clr_n),
        .frm_start_i(frm_start), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .cmd_oper_i(cmd_oper), .code_o(code_o), .mode_o(mode_o));

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            chk(tag, code_o[i*16 +: 16], exp_code[i]);
            chk(tag, 16'(mode_o[i*2 +: 2]), 16'(exp_mode[i]));
        end
    endtask

    task automatic set_all(input logic [15:0] v);
        for (int i = 0; i < 4; i++) exp_code[i] = v;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] addr, input logic [19:0] oper);
        @(negedge clk) frm_start = 1'b1;
        @(negedge clk) frm_start = 1'b0;
        cycles(2);
        cmd_op = op; cmd_addr = addr; cmd_oper = oper; cmd_valid = 1'b1;
        @(negedge clk) cmd_valid = 1'b0;
        cycles(1);
    endtask

    function automatic logic [19:0] cw(input logic [15:0] code);
        return {code, 4'h0};
    endfunction

    task automatic t_reset;
        por_mid = 1'b0; rst = 1'b1; cycles(3); rst = 1'b0; cycles(1);
        set_all(16'h0000); for (int i = 0; i < 4; i++) exp_mode[i] = 2'b00;
        check_all("R1 strap low");
        por_mid = 1'b1; rst = 1'b1; cycles(3); rst = 1'b0; cycles(1);
        set_all(16'h8000);
        check_all("R1 strap high");
    endtask

    task automatic t_write_update;
        send(4'h0, 4'h0, cw(16'h1234));
        check_all("R2 input only");
        send(4'h1, 4'h0, 20'h0);
        exp_code[0] = 16'h1234;
        check_all("R3 update n");
    endtask

    task automatic t_address;
        send(4'h3, 4'h2, cw(16'h3333)); exp_code[2] = 16'h3333;
        send(4'h3, 4'h3, cw(16'h4444)); exp_code[3] = 16'h4444;
        check_all("R5 R6 write-update C D");
        send(4'h3, 4'h5, cw(16'h5555));
        check_all("R6 reserved address");
        send(4'h3, 4'hF, cw(16'h7777)); set_all(16'h7777);
        check_all("R6 broadcast");
        send(4'h0, 4'h1, cw(16'h0B0B));
        check_all("R2 staged B");
        send(4'h2, 4'h0, cw(16'h0A0A));
        exp_code[0] = 16'h0A0A; exp_code[1] = 16'h0B0B;
        check_all("R4 update all");
    endtask

    task automatic t_power;
        send(4'h4, 4'h0, 20'h00205);
        exp_mode[0] = 2'b10; exp_mode[2] = 2'b10;
        check_all("R7 power-down A C");
        send(4'h0, 4'h0, cw(16'h1111));
        send(4'h4, 4'h0, 20'h00001);
        exp_mode[0] = 2'b00;
        check_all("R14 power-up keeps code");
        upd_n = 1'b0; cycles(4);
        exp_code[0] = 16'h1111;
        check_all("R10 R14 pin low takes staged");
        upd_n = 1'b1; cycles(4);
    endtask

    task automatic t_mask;
        send(4'h6, 4'h0, 20'h00002);
        send(4'h0, 4'h1, cw(16'h2222)); exp_code[1] = 16'h2222;
        check_all("R9 masked channel follows");
        send(4'h0, 4'h2, cw(16'h3030));
        check_all("R9 unmasked channel holds");
        upd_n = 1'b0; cycles(4);
        exp_code[2] = 16'h3030;
        check_all("R10 pin low copies");
        send(4'h0, 4'h3, cw(16'h4D4D)); exp_code[3] = 16'h4D4D;
        check_all("R10 write with pin low");
        upd_n = 1'b1; cycles(4);
    endtask

    task automatic t_clear;
        send(4'h5, 4'h0, 20'h00002);
        clr_n = 1'b0; cycles(5); set_all(16'hFFFF);
        check_all("R11 R8 clear full");
        send(4'h0, 4'h0, cw(16'h0101));
        upd_n = 1'b0; cycles(5);
        check_all("R11 pin ignored while clear low");
        upd_n = 1'b1; cycles(4);
        clr_n = 1'b1; cycles(4);
        send(4'h5, 4'h0, 20'h00001);
        send(4'h5, 4'h0, 20'h00003);
        clr_n = 1'b0; cycles(5); set_all(16'h8000);
        check_all("R8 keep value is no-op");
        clr_n = 1'b1; cycles(4);
        send(4'h5, 4'h0, 20'h00000);
    endtask

    task automatic t_abort;
        @(negedge clk) frm_start = 1'b1;
        @(negedge clk) frm_start = 1'b0;
        clr_n = 1'b0; cycles(5);
        cmd_op = 4'h3; cmd_addr = 4'h0; cmd_oper = cw(16'h9999); cmd_valid = 1'b1;
        @(negedge clk) cmd_valid = 1'b0;
        cycles(1); set_all(16'h0000);
        check_all("R12 aborted frame");
        clr_n = 1'b1; cycles(4);
        send(4'h3, 4'h0, cw(16'h9999)); exp_code[0] = 16'h9999;
        check_all("R12 next frame acts");
    endtask

    task automatic t_illegal;
        for (int op = 8; op < 16; op++) send(4'(op), 4'hF, 20'hABCDF);
        check_all("R13 reserved opcodes");
    endtask

    task automatic t_swreset;
        send(4'h5, 4'h0, 20'h00002);
        por_mid = 1'b0;
        send(4'h7, 4'h0, 20'h0);
        set_all(16'h0000); for (int i = 0; i < 4; i++) exp_mode[i] = 2'b00;
        check_all("R1 software reset");
        send(4'h0, 4'h1, cw(16'h5A5A));
        check_all("R1 mask cleared");
        send(4'h3, 4'h2, cw(16'h6666)); exp_code[2] = 16'h6666;
        clr_n = 1'b0; cycles(5); set_all(16'h0000);
        check_all("R1 clear code reset to zero");
        clr_n = 1'b1; cycles(4);
    endtask

    initial begin
        t_reset();
        t_write_update();
        t_address();
        t_power();
        t_mask();
        t_clear();
        t_abort();
        t_illegal();
        t_swreset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run hung got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule